// File: doc/BRIEF.md
# Multichannel PWM Generator with Break

A timer block that produces pulse-width modulated waveforms on several channels from one shared up-counter. A prescaler divides the input clock. The counter then counts from zero up to a reload value and wraps, and each wrap raises an update event. Each channel compares the counter with its own compare value to form a reference waveform. The reference drives a main output and a complementary output, and each of these has its own enable and polarity bit.

The prescaler, the reload value and the compare values are held as written values and as working copies. With preloading enabled, a new value reaches the waveform only at an update event, so the PWM period stays glitch-free. A software update command forces that transfer at once and restarts the count. A master output enable gates every output. Filtered break inputs can clear it, which parks all outputs at their idle level until software turns them on again.

Configuration uses a single-cycle register write port: `wr_en`, a 4-bit address and a data word.

Top module: `pwm_break_timer`

## Requirements
- R1: Register map (address: content). 0: control, bit0 counter enable, bit1 reload preload enable, bit 2+k compare preload enable of channel k. 1: prescaler. 2: reload. 3+k: compare value of channel k. 7: output control. 8: break setup. 9: master output enable, bit0 (1 sets, 0 clears). 10: update command (data ignored). With prescaler P and reload A, the counter steps every P+1 clocks, runs 0..A, wraps to 0 and raises an update event, so the period is (P+1)*(A+1) clocks.
- R2: A channel's reference is active while counter < compare value, so its high time is (P+1)*C clocks per period.
- R3: With reload preload set, a written reload value takes effect at the next update event. With it clear, the value takes effect at once.
- R4: With a channel's compare preload bit set, a new compare value takes effect at the next update event. With the bit clear, it takes effect at once.
- R5: A write to the update command copies the prescaler, reload and compare values into their working copies and clears the prescaler count and the counter, in the same clock edge. This happens even while the counter is disabled.
- R6: The counter and the prescaler count hold their values while counter enable is 0.
- R7: Output control holds 4 bits per channel k, starting at bit 4k: main enable, main polarity, complementary enable, complementary polarity. A main output shows reference XOR polarity. A complementary output shows (NOT reference) XOR its polarity.
- R8: While the master enable is 0, or while an output's own enable is 0, that output sits at its polarity bit value (its idle level). The reset values are all zero, so every output is 0 after reset.
- R9: Break input j is set up by bits [6j+5:6j] of the break setup register: bit 6j enable, bit 6j+1 active level, bits 6j+5:6j+2 filter N (0..15). A break is accepted when the enabled input has been at its active level for max(N,1) consecutive clocks. The accepted break clears the master enable at that clock edge and overrides a software set in the same cycle. The master enable stays 0 until software writes it to 1.
- R10: The prescaler value takes effect only at an update event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| brk_in | input | 2 | Break inputs |
| pwm_out | output | 4 | Main channel outputs |
| pwm_out_n | output | 4 | Complementary channel outputs |

## Verification
A wrong counter, prescaler count or working copy shows on the outputs as an edge in the wrong place, at the latest at the next compare crossing or wrap, so within one PWM period. A wrong master enable or break filter count shows within a clock: the outputs either park at their idle level too early or keep toggling after a break that should have been accepted. The bench keeps its own cycle model of the timer and compares all outputs on every clock. It mixes random register traffic and break activity with directed runs on duty measurement, filter lengths below and at the threshold, and recovery after a break.

// File: rtl/pwmb_pkg.sv
package pwmb_pkg;
   localparam int ADDR_W   = 4;
   localparam int A_CTRL   = 0;
   localparam int A_PSC    = 1;
   localparam int A_RELOAD = 2;
   localparam int A_CMP0   = 3;
   localparam int A_OUTCTL = 7;
   localparam int A_BRK    = 8;
   localparam int A_MOE    = 9;
   localparam int A_UPDATE = 10;
   localparam int OUT_STRIDE = 4;

   typedef struct packed {
      logic cpol;
      logic cen;
      logic pol;
      logic en;
   } chan_ctl_t;
endpackage

// File: rtl/pwmb_timebase.sv
module pwmb_timebase #(
   parameter int CNT_W = 16,
   parameter int PSC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic             ug,
   input  logic             arpe,
   input  logic [PSC_W-1:0] psc_reg,
   input  logic [CNT_W-1:0] arr_reg,
   output logic [CNT_W-1:0] cnt,
   output logic [PSC_W-1:0] psc_cnt,
   output logic             ovf,
   output logic             ue
);
   logic [PSC_W-1:0] psc_act;
   logic [CNT_W-1:0] arr_act;
   logic [CNT_W-1:0] arr_eff;
   logic             tick;

   assign arr_eff = arpe ? arr_act : arr_reg;
   assign tick    = cnt_en && (psc_cnt == psc_act);
   assign ovf     = tick && (cnt == arr_eff);
   assign ue      = ovf || ug;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_cnt <= '0;
         cnt     <= '0;
      end else if (ug) begin
         psc_cnt <= '0;
         cnt     <= '0;
      end else if (cnt_en) begin
         if (tick) begin
            psc_cnt <= '0;
            cnt     <= ovf ? '0 : cnt + 1'b1;
         end else begin
            psc_cnt <= psc_cnt + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_act <= '0;
         arr_act <= '0;
      end else if (ue) begin
         psc_act <= psc_reg;
         arr_act <= arr_reg;
      end
   end
endmodule

// File: rtl/pwmb_channel.sv
module pwmb_channel
   import pwmb_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter bit HAS_COMP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic             ue,
   input  logic             ccpe,
   input  logic [CNT_W-1:0] ccr_reg,
   input  logic             moe,
   input  chan_ctl_t        ctl,
   output logic             out,
   output logic             out_n
);
   logic [CNT_W-1:0] ccr_act;
   logic [CNT_W-1:0] ccr_eff;
   logic             ref_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ccr_act <= '0;
      else if (ue) ccr_act <= ccr_reg;
   end

   assign ccr_eff = ccpe ? ccr_act : ccr_reg;
   assign ref_w   = cnt < ccr_eff;
   assign out     = (moe && ctl.en) ? (ref_w ^ ctl.pol) : ctl.pol;

   generate
      if (HAS_COMP) begin : g_comp
         assign out_n = (moe && ctl.cen) ? (~ref_w ^ ctl.cpol) : ctl.cpol;
      end else begin : g_nocomp
         logic unused_comp;
         assign unused_comp = ctl.cen ^ ctl.cpol;
         assign out_n = 1'b0 & unused_comp;
      end
   endgenerate
endmodule

// File: rtl/pwmb_break.sv
module pwmb_break #(
   parameter int FILT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              brk_in,
   input  logic              en,
   input  logic              lvl,
   input  logic [FILT_W-1:0] filt,
   output logic              accept
);
   logic [FILT_W-1:0] run;
   logic [FILT_W:0]   need;
   logic              active;

   assign active = en && (brk_in == lvl);
   assign need   = (filt == '0) ? (FILT_W+1)'(1) : {1'b0, filt};
   assign accept = active && (({1'b0, run} + 1'b1) >= need);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run <= '0;
      else if (!active) run <= '0;
      else if (run != {FILT_W{1'b1}}) run <= run + 1'b1;
   end
endmodule

// File: rtl/pwm_break_timer.sv
module pwm_break_timer
   import pwmb_pkg::*;
#(
   parameter int NCH      = 4,
   parameter int NBRK     = 2,
   parameter int CNT_W    = 16,
   parameter int PSC_W    = 16,
   parameter int FILT_W   = 4,
   parameter int DATA_W   = 16,
   parameter bit HAS_COMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [NBRK-1:0]   brk_in,
   output logic [NCH-1:0]    pwm_out,
   output logic [NCH-1:0]    pwm_out_n
);
   localparam int BRK_FW = 2 + FILT_W;
   localparam int CTL_W  = OUT_STRIDE * NCH;
   localparam int CTRL_W = 2 + NCH;

   generate
      if (NCH < 1 || NCH > 4) begin : g_bad_nch
         $error("NCH must be 1..4");
      end
      if (NBRK < 1 || BRK_FW * NBRK > DATA_W) begin : g_bad_brk
         $error("break setup does not fit the data word");
      end
      if (CNT_W > DATA_W || PSC_W > DATA_W || CTL_W > DATA_W) begin : g_bad_w
         $error("register wider than the data word");
      end
   endgenerate

   logic [CTRL_W-1:0]      ctrl_q;
   logic [PSC_W-1:0]       psc_q;
   logic [CNT_W-1:0]       arr_q;
   logic [CNT_W-1:0]       ccr_q [NCH];
   logic [CTL_W-1:0]       outctl_q;
   logic [BRK_FW*NBRK-1:0] brk_q;
   logic                   moe_q;
   logic                   ug;
   logic [NBRK-1:0]        brk_acc;
   logic [CNT_W-1:0]       cnt;
   logic [PSC_W-1:0]       psc_cnt;
   logic                   ovf;
   logic                   ue;

   assign ug = wr_en && (int'(wr_addr) == A_UPDATE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         psc_q    <= '0;
         arr_q    <= '0;
         outctl_q <= '0;
         brk_q    <= '0;
         for (int k = 0; k < NCH; k++) ccr_q[k] <= '0;
      end else if (wr_en) begin
         if (int'(wr_addr) == A_CTRL)   ctrl_q   <= wr_data[CTRL_W-1:0];
         if (int'(wr_addr) == A_PSC)    psc_q    <= wr_data[PSC_W-1:0];
         if (int'(wr_addr) == A_RELOAD) arr_q    <= wr_data[CNT_W-1:0];
         if (int'(wr_addr) == A_OUTCTL) outctl_q <= wr_data[CTL_W-1:0];
         if (int'(wr_addr) == A_BRK)    brk_q    <= wr_data[BRK_FW*NBRK-1:0];
         for (int k = 0; k < NCH; k++)
            if (int'(wr_addr) == A_CMP0 + k) ccr_q[k] <= wr_data[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       moe_q <= 1'b0;
      else if (|brk_acc)                                moe_q <= 1'b0;
      else if (wr_en && (int'(wr_addr) == A_MOE))       moe_q <= wr_data[0];
   end

   pwmb_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) tb_i (
      .clk(clk), .rst_n(rst_n), .cnt_en(ctrl_q[0]), .ug(ug), .arpe(ctrl_q[1]),
      .psc_reg(psc_q), .arr_reg(arr_q), .cnt(cnt), .psc_cnt(psc_cnt),
      .ovf(ovf), .ue(ue)
   );

   for (genvar k = 0; k < NCH; k++) begin : g_ch
      pwmb_channel #(.CNT_W(CNT_W), .HAS_COMP(HAS_COMP)) ch_i (
         .clk(clk), .rst_n(rst_n), .cnt(cnt), .ue(ue), .ccpe(ctrl_q[2+k]),
         .ccr_reg(ccr_q[k]), .moe(moe_q),
         .ctl(chan_ctl_t'(outctl_q[OUT_STRIDE*k +: OUT_STRIDE])),
         .out(pwm_out[k]), .out_n(pwm_out_n[k])
      );
   end

   for (genvar j = 0; j < NBRK; j++) begin : g_brk
      pwmb_break #(.FILT_W(FILT_W)) brk_i (
         .clk(clk), .rst_n(rst_n), .brk_in(brk_in[j]),
         .en(brk_q[BRK_FW*j]), .lvl(brk_q[BRK_FW*j+1]),
         .filt(brk_q[BRK_FW*j+2 +: FILT_W]), .accept(brk_acc[j])
      );
   end
endmodule

// File: rtl/pwm_break_timer_chk.sv
module pwm_break_timer_chk #(
   parameter int NCH      = 4,
   parameter int NBRK     = 2,
   parameter int CNT_W    = 16,
   parameter int PSC_W    = 16,
   parameter bit HAS_COMP = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_en,
   input logic             ug,
   input logic             ovf,
   input logic [CNT_W-1:0] cnt,
   input logic [PSC_W-1:0] psc_cnt,
   input logic             moe,
   input logic [NBRK-1:0]  brk_acc,
   input logic [4*NCH-1:0] outctl,
   input logic [NCH-1:0]   pwm_out,
   input logic [NCH-1:0]   pwm_out_n
);
   logic [NCH-1:0] pol_v;
   logic [NCH-1:0] cpol_v;
   for (genvar k = 0; k < NCH; k++) begin : g_pol
      assign pol_v[k]  = outctl[4*k+1];
      assign cpol_v[k] = HAS_COMP ? outctl[4*k+3] : 1'b0;
   end

   assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> (cnt == '0));

   assert_ug_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ug |=> (cnt == '0 && psc_cnt == '0));

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !ug) |=> ($stable(cnt) && $stable(psc_cnt)));

   assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !moe |-> (pwm_out == pol_v && pwm_out_n == cpol_v));

   assert_break_cut_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|brk_acc) |=> !moe);
endmodule

bind pwm_break_timer pwm_break_timer_chk #(
   .NCH(NCH), .NBRK(NBRK), .CNT_W(CNT_W), .PSC_W(PSC_W), .HAS_COMP(HAS_COMP)
) chk_i (
   .clk(clk), .rst_n(rst_n), .cnt_en(ctrl_q[0]), .ug(ug), .ovf(ovf),
   .cnt(cnt), .psc_cnt(psc_cnt), .moe(moe_q), .brk_acc(brk_acc),
   .outctl(outctl_q), .pwm_out(pwm_out), .pwm_out_n(pwm_out_n)
);

// File: tb/pwm_break_timer_tb_top.sv
`timescale 1ns/1ps
module pwm_break_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  brk_in = '0;
   logic [3:0]  pwm_out, pwm_out_n;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   string tag = "R8";

   always #2.5 clk = ~clk;

   pwm_break_timer dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .brk_in(brk_in), .pwm_out(pwm_out), .pwm_out_n(pwm_out_n)
   );

   // bench reference model, built from the requirements
   logic [5:0]  m_ctrl;
   logic [15:0] m_psc, m_arr, m_psc_act, m_arr_act, m_pc, m_cnt, m_outctl, m_brk;
   logic [15:0] m_ccr [4];
   logic [15:0] m_ccr_act [4];
   int          m_run [2];
   logic        m_moe;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl = '0; m_psc = '0; m_arr = '0; m_psc_act = '0; m_arr_act = '0;
         m_pc = '0; m_cnt = '0; m_outctl = '0; m_brk = '0; m_moe = 1'b0;
         for (int k = 0; k < 4; k++) begin m_ccr[k] = '0; m_ccr_act[k] = '0; end
         for (int j = 0; j < 2; j++) m_run[j] = 0;
      end else begin
         logic ug, tick, ovf, any_acc;
         logic [15:0] aeff;
         ug   = wr_en && wr_addr == 4'd10;
         aeff = m_ctrl[1] ? m_arr_act : m_arr;
         tick = m_ctrl[0] && m_pc == m_psc_act;
         ovf  = tick && m_cnt == aeff;
         any_acc = 1'b0;
         for (int j = 0; j < 2; j++) begin
            logic act; int need; int filt;
            act  = m_brk[6*j] && (brk_in[j] == m_brk[6*j+1]);
            filt = int'(m_brk[6*j+2 +: 4]);
            need = (filt == 0) ? 1 : filt;
            if (act && m_run[j] + 1 >= need) any_acc = 1'b1;
            m_run[j] = act ? ((m_run[j] == 15) ? 15 : m_run[j] + 1) : 0;
         end
         if (ovf || ug) begin
            m_psc_act = m_psc; m_arr_act = m_arr;
            for (int k = 0; k < 4; k++) m_ccr_act[k] = m_ccr[k];
         end
         if (ug) begin m_pc = '0; m_cnt = '0; end
         else if (m_ctrl[0]) begin
            if (tick) begin m_pc = '0; m_cnt = ovf ? 16'd0 : m_cnt + 16'd1; end
            else m_pc = m_pc + 16'd1;
         end
         if (any_acc) m_moe = 1'b0;
         else if (wr_en && wr_addr == 4'd9) m_moe = wr_data[0];
         if (wr_en) begin
            case (wr_addr)
               4'd0: m_ctrl = wr_data[5:0];
               4'd1: m_psc = wr_data;
               4'd2: m_arr = wr_data;
               4'd3, 4'd4, 4'd5, 4'd6: m_ccr[wr_addr-4'd3] = wr_data;
               4'd7: m_outctl = wr_data;
               4'd8: m_brk = {4'd0, wr_data[11:0]};
               default: ;
            endcase
         end
      end
   end

   function automatic logic [7:0] exp_outs();
      logic [3:0] o, on;
      for (int k = 0; k < 4; k++) begin
         logic r;
         logic [15:0] c;
         c = m_ctrl[2+k] ? m_ccr_act[k] : m_ccr[k];
         r = m_cnt < c;
         o[k]  = (m_moe && m_outctl[4*k])   ? (r ^ m_outctl[4*k+1])  : m_outctl[4*k+1];
         on[k] = (m_moe && m_outctl[4*k+2]) ? (~r ^ m_outctl[4*k+3]) : m_outctl[4*k+3];
      end
      return {on, o};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) check(tag, {pwm_out_n, pwm_out}, exp_outs());
   end

   task automatic wr(input int a, input int d);
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int hi, lo;
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      check("R8 reset", {pwm_out_n, pwm_out}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 after reset", {pwm_out_n, pwm_out}, 8'h00);

      // R2 R1: duty and period with prescaler 1, reload 4, compare 2
      tag = "R2";
      wr(1, 1); wr(2, 4); wr(3, 2); wr(7, 16'h0005); wr(9, 1);
      tag = "R5"; wr(10, 0);
      tag = "R6"; idle(6);
      tag = "R1"; wr(0, 1);
      hi = 0; lo = 0;
      for (int i = 0; i < 10; i++) begin
         if (pwm_out[0]) hi++;
         if (pwm_out_n[0]) lo++;
         @(negedge clk);
      end
      check("R2 high time", 32'(hi), 32'd4);
      check("R7 complement high time", 32'(lo), 32'd6);

      // R3: reload preload on, new reload deferred; R10 prescaler deferred
      tag = "R3"; wr(0, 3); wr(2, 7); idle(25);
      tag = "R10"; wr(1, 0); idle(20);
      tag = "R3"; wr(0, 1); wr(2, 3); idle(12);
      // R4: compare preload on channel 1
      tag = "R4"; wr(7, 16'h0055); wr(0, 16'h0009); wr(4, 3); idle(10);
      wr(0, 1); wr(4, 1); idle(8);
      // R7: polarity inversions on all channels
      tag = "R7"; wr(7, 16'hFFFF); wr(5, 2); wr(6, 4); idle(12);
      wr(7, 16'hA5A5); idle(10);
      // R9: filter 3, pulse of 2 must not cut, pulse of 3 must cut
      tag = "R9"; wr(7, 16'h0005); wr(8, 16'h000F);
      brk_in[0] = 1'b1; idle(2); brk_in[0] = 1'b0; idle(4);
      check("R9 short pulse keeps outputs", 32'(m_moe), 32'd1);
      brk_in[0] = 1'b1; idle(3); brk_in[0] = 1'b0;
      check("R9 idle after break", {pwm_out_n[0], pwm_out[0]}, 2'b00);
      idle(6);
      check("R9 stays cut", {pwm_out_n[0], pwm_out[0]}, 2'b00);
      wr(9, 1); idle(6);
      // break with filter 0 on input 1, active low, collides with a software set
      wr(8, 16'h0040);
      brk_in[1] = 1'b1; idle(2); brk_in[1] = 1'b0; wr(9, 1); brk_in[1] = 1'b1;
      idle(4);
      check("R9 break beats set", {pwm_out_n[0], pwm_out[0]}, 2'b00);

      // constrained random traffic
      tag = "R8";
      for (int it = 0; it < 6000; it++) begin
         int a, d, r;
         if ($urandom_range(7) == 0) brk_in = 2'($urandom_range(3));
         r = $urandom_range(9);
         if (r < 4) begin
            a = $urandom_range(10);
            case (a)
               0: d = $urandom_range(63);
               1: d = $urandom_range(3);
               2: d = $urandom_range(12);
               3, 4, 5, 6: d = $urandom_range(14);
               7: d = $urandom_range(16'hFFFF);
               8: d = ($urandom_range(3) == 0) ? $urandom_range(12'hFFF) : 0;
               9: d = 1;
               default: d = 0;
            endcase
            wr(a, d);
         end else begin
            @(negedge clk);
         end
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule